// File: doc/BRIEF.md
# Clock-Stabilization Reset and Stop-Recovery Sequencer

This block orders the start of a small microcontroller after power-on, after a supply-low trip, and after it wakes from stop mode. One prescaler counter does three jobs. It stretches the reset pin pulse. It times the oscillator settling before the bus clocks come back after stop. It divides the clock down to a slow tick for a watchdog.

A reset request puts the block into a hold phase. In that phase it drives the reset pin low and keeps the bus clocks off for a full counter period of 4096 cycles. The pin is then released. The CPU and memories stay in reset, with the bus clock running, for 64 more cycles before they start fetching. A stop request clears the counter and gates the bus clocks off. A wake event then starts either the long 4096-cycle recovery or a short 32-cycle recovery, as picked by an option bit.

Top module: `clkstab_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rst_pin_low`=1, `cpu_rst`=1, `bus_clk_en`=0, `wdog_tick`=0 and `rst_status`=2'b01.
- R2: A cycle with `por_req` or `lvd_trip` high sets `rst_pin_low` from the next cycle. It stays 1, with `bus_clk_en`=0, for exactly 4096 cycles after the last request cycle.
- R3: When `rst_pin_low` falls, `cpu_rst` stays 1 for exactly 64 more cycles. `bus_clk_en` is 1 during those cycles and after them.
- R4: A new reset request during a reset sequence restarts the 4096-cycle pin-low interval from zero.
- R5: `rst_status` bit 0 is the power-on source and bit 1 is the low-voltage source. `por_req` sets the field to 2'b01. `lvd_trip` alone sets bit 1 and keeps bit 0. A `stat_clr` pulse clears both bits, unless a request arrives in the same cycle.
- R6: `stop_req` while running (`cpu_rst`=0, `bus_clk_en`=1) drops `bus_clk_en` from the next cycle and clears the counter.
- R7: A `wake_evt` in stop mode with `short_wake`=0 brings `bus_clk_en` back after exactly 4096 cycles.
- R8: A `wake_evt` in stop mode with `short_wake`=1 brings `bus_clk_en` back after exactly 32 cycles. `short_wake` is sampled in the wake cycle.
- R9: `wake_evt` outside stop mode and `stop_req` outside the running state have no effect on the outputs.
- R10: `wdog_tick` is a one-cycle pulse. It comes at the start of cycle 4096·k of an unbroken run phase (k ≥ 1), counting the first run cycle as 0.
- R11: A reset request during stop or wake recovery aborts it and starts the reset hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Doubled oscillator clock |
| rst | input | 1 | Synchronous active-high reset, handled like a power-on request |
| por_req | input | 1 | Power-on reset request |
| lvd_trip | input | 1 | Supply-low detector trip |
| stop_req | input | 1 | Enter stop mode (one-cycle pulse) |
| wake_evt | input | 1 | Interrupt, break or reset wake event |
| short_wake | input | 1 | 1 = short 32-cycle stop recovery |
| stat_clr | input | 1 | Clear pulse for the reset source bits |
| rst_pin_low | output | 1 | 1 = drive the open-drain reset pin low |
| cpu_rst | output | 1 | 1 = CPU and memories held in reset |
| bus_clk_en | output | 1 | Bus clock enable |
| rst_status | output | 2 | Reset source bits {low-voltage, power-on} |
| wdog_tick | output | 1 | Watchdog prescaler tick |

## Verification
A cycle-level reference model tracks the phases with countdowns and a run-age count, and every output is compared with it on every clock. The first pattern is a plain reset. It separates the 4096-cycle pin stretch from the 64-cycle CPU hold. Stop with the short option, then stop with the long option, tells whether the option bit is sampled and whether the counter really restarts at stop. Repeated supply trips inside a hold and a power-on request during stop check the restart and abort paths and the status bit priority. A long idle run counts watchdog ticks and checks their spacing.

// File: rtl/clkstab_pkg.sv
package clkstab_pkg;
  typedef enum logic [2:0] {
    PH_HOLD = 3'd0,
    PH_REL  = 3'd1,
    PH_RUN  = 3'd2,
    PH_STOP = 3'd3,
    PH_WAKE = 3'd4
  } phase_t;

  localparam int SRC_POR = 0;
  localparam int SRC_LVD = 1;
  localparam int SRC_W   = 2;
endpackage

// File: rtl/clkstab_presc.sv
module clkstab_presc #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en)
      cnt <= cnt + 1'b1;
  end

  // carry out of the last counting stage
  assign wrap = en && !clr && (cnt == LAST);
endmodule

// File: rtl/clkstab_fsm.sv
module clkstab_fsm
  import clkstab_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int REL_LEN   = 64,
  parameter int SHORT_LEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             stop_req,
  input  logic             wake_evt,
  input  logic             short_wake,
  input  logic [CNT_W-1:0] cnt,
  output phase_t           phase,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             pin_low_q,
  output logic             cpu_rst_q,
  output logic             bus_en_q
);
  localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] REL_LAST   = CNT_W'(REL_LEN - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);

  phase_t nxt;
  logic   short_q;
  logic   wake_done;

  assign wake_done = (cnt == (short_q ? SHORT_LAST : LONG_LAST));

  always_comb begin
    nxt = phase;
    if (req) begin
      nxt = PH_HOLD;
    end else begin
      case (phase)
        PH_HOLD: if (cnt == LONG_LAST) nxt = PH_REL;
        PH_REL:  if (cnt == REL_LAST)  nxt = PH_RUN;
        PH_RUN:  if (stop_req)         nxt = PH_STOP;
        PH_STOP: if (wake_evt)         nxt = PH_WAKE;
        PH_WAKE: if (wake_done)        nxt = PH_RUN;
        default:                       nxt = PH_HOLD;
      endcase
    end
  end

  assign cnt_clr = req || (nxt != phase) || (phase == PH_STOP);
  assign cnt_en  = (phase != PH_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HOLD;
      short_q   <= 1'b0;
      pin_low_q <= 1'b1;
      cpu_rst_q <= 1'b1;
      bus_en_q  <= 1'b0;
    end else begin
      phase     <= nxt;
      if (phase == PH_STOP && wake_evt)
        short_q <= short_wake;
      pin_low_q <= (nxt == PH_HOLD);
      cpu_rst_q <= (nxt == PH_HOLD) || (nxt == PH_REL);
      bus_en_q  <= (nxt == PH_REL) || (nxt == PH_RUN);
    end
  end
endmodule

// File: rtl/clkstab_status.sv
module clkstab_status
  import clkstab_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              por_set,
  input  logic              lvd_set,
  input  logic              clr,
  output logic [SRC_W-1:0]  src
);
  always_ff @(posedge clk) begin
    if (rst || por_set) begin
      src          <= '0;
      src[SRC_POR] <= 1'b1;
    end else if (lvd_set) begin
      src[SRC_LVD] <= 1'b1;
    end else if (clr) begin
      src <= '0;
    end
  end
endmodule

// File: rtl/clkstab_seq.sv
module clkstab_seq
  import clkstab_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int REL_LEN   = 64,
  parameter int SHORT_LEN = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_req,
  input  logic       lvd_trip,
  input  logic       stop_req,
  input  logic       wake_evt,
  input  logic       short_wake,
  input  logic       stat_clr,
  output logic       rst_pin_low,
  output logic       cpu_rst,
  output logic       bus_clk_en,
  output logic [1:0] rst_status,
  output logic       wdog_tick
);
  logic [CNT_W-1:0] cnt;
  logic             wrap, cnt_clr, cnt_en, req;
  phase_t           phase;

  assign req = por_req || lvd_trip;

  clkstab_presc #(.CNT_W(CNT_W)) u_presc (
    .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en), .cnt(cnt), .wrap(wrap)
  );

  clkstab_fsm #(.CNT_W(CNT_W), .REL_LEN(REL_LEN), .SHORT_LEN(SHORT_LEN)) u_fsm (
    .clk(clk), .rst(rst), .req(req), .stop_req(stop_req), .wake_evt(wake_evt),
    .short_wake(short_wake), .cnt(cnt), .phase(phase), .cnt_clr(cnt_clr),
    .cnt_en(cnt_en), .pin_low_q(rst_pin_low), .cpu_rst_q(cpu_rst),
    .bus_en_q(bus_clk_en)
  );

  clkstab_status u_status (
    .clk(clk), .rst(rst), .por_set(por_req), .lvd_set(lvd_trip),
    .clr(stat_clr), .src(rst_status)
  );

  // extra stage past the counter: one pulse per full period while running
  always_ff @(posedge clk) begin
    if (rst)
      wdog_tick <= 1'b0;
    else
      wdog_tick <= wrap && (phase == PH_RUN);
  end
endmodule

// File: rtl/clkstab_seq_chk.sv
module clkstab_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_req,
  input logic       lvd_trip,
  input logic       stop_req,
  input logic       wake_evt,
  input logic       rst_pin_low,
  input logic       cpu_rst,
  input logic       bus_clk_en,
  input logic [1:0] rst_status,
  input logic       wdog_tick
);
  // R2
  pin_gates_bus_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pin_low |-> !bus_clk_en);

  // R3
  cpu_held_after_pin_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pin_low) |-> (cpu_rst && bus_clk_en));

  // R4
  req_restarts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (por_req || lvd_trip) |=> (rst_pin_low && cpu_rst));

  // R5
  por_source_chk: assert property (@(posedge clk) disable iff (rst)
    por_req |=> (rst_status == 2'b01));

  // R6
  stop_gates_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_clk_en && !cpu_rst && stop_req && !por_req && !lvd_trip) |=> !bus_clk_en);

  // R9
  stray_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_clk_en && !cpu_rst && wake_evt && !stop_req && !por_req && !lvd_trip)
      |=> (bus_clk_en && !cpu_rst));

  // R10
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_tick |=> !wdog_tick);
endmodule

bind clkstab_seq clkstab_seq_chk u_chk (
  .clk(clk), .rst(rst), .por_req(por_req), .lvd_trip(lvd_trip),
  .stop_req(stop_req), .wake_evt(wake_evt), .rst_pin_low(rst_pin_low),
  .cpu_rst(cpu_rst), .bus_clk_en(bus_clk_en), .rst_status(rst_status),
  .wdog_tick(wdog_tick)
);

// File: tb/clkstab_seq_bench.sv
module clkstab_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_req = 1'b0, lvd_trip = 1'b0, stop_req = 1'b0, wake_evt = 1'b0;
  logic short_wake = 1'b0, stat_clr = 1'b0;
  logic rst_pin_low, cpu_rst, bus_clk_en, wdog_tick;
  logic [1:0] rst_status;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference model: 0 hold, 1 release, 2 run, 3 stop, 4 wake
  int m_mode = 0, m_left = 4096, m_age = 0;
  logic [1:0] m_stat = 2'b01;
  logic m_tick = 1'b0;

  clkstab_seq u_clkstab_seq (
    .clk(clk), .rst(rst), .por_req(por_req), .lvd_trip(lvd_trip),
    .stop_req(stop_req), .wake_evt(wake_evt), .short_wake(short_wake),
    .stat_clr(stat_clr), .rst_pin_low(rst_pin_low), .cpu_rst(cpu_rst),
    .bus_clk_en(bus_clk_en), .rst_status(rst_status), .wdog_tick(wdog_tick)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_left = 4096; m_age = 0; m_stat = 2'b01; m_tick = 1'b0;
    end else begin
      m_tick = (m_mode == 2) && !por_req && !lvd_trip && !stop_req &&
               (((m_age + 1) % 4096) == 0);
      if (por_req || lvd_trip) begin
        if (por_req) m_stat = 2'b01;
        else m_stat[1] = 1'b1;
        m_mode = 0; m_left = 4096;
      end else begin
        if (stat_clr) m_stat = 2'b00;
        case (m_mode)
          0: begin m_left--; if (m_left == 0) begin m_mode = 1; m_left = 64; end end
          1: begin m_left--; if (m_left == 0) begin m_mode = 2; m_age = 0; end end
          2: begin m_age++; if (stop_req) m_mode = 3; end
          3: if (wake_evt) begin m_mode = 4; m_left = short_wake ? 32 : 4096; end
          default: begin m_left--; if (m_left == 0) begin m_mode = 2; m_age = 0; end end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      logic [5:0] act, exp;
      string tag;
      act = {rst_pin_low, cpu_rst, bus_clk_en, rst_status, wdog_tick};
      exp = {m_mode == 0, m_mode <= 1, (m_mode == 1) || (m_mode == 2), m_stat, m_tick};
      case (m_mode)
        0: tag = "R2";
        1: tag = "R3";
        2: tag = "R10";
        3: tag = "R6";
        default: tag = "R7/R8 wake";
      endcase
      chk(act == exp, tag, {2'b0, act}, {2'b0, exp});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
  endtask

  task automatic pulse_wake(input logic sh);
    @(negedge clk) begin wake_evt = 1'b1; short_wake = sh; end
    @(negedge clk) begin wake_evt = 1'b0; short_wake = ~sh; end
  endtask

  initial begin
    int ticks;
    logic prev;
    wait_cyc(3);
    chk(rst_pin_low && cpu_rst && !bus_clk_en && rst_status == 2'b01 && !wdog_tick,
        "R1", {3'b0, rst_pin_low, cpu_rst, bus_clk_en, rst_status}, 8'h19);
    @(negedge clk) rst = 1'b0;
    chk(rst_pin_low && cpu_rst && !bus_clk_en && rst_status == 2'b01,
        "R1", {4'b0, rst_pin_low, cpu_rst, bus_clk_en, wdog_tick}, 8'h0c);
    // R2 / R3: pin stretch then CPU hold
    wait_cyc(4000);
    chk(rst_pin_low, "R2", {7'b0, rst_pin_low}, 8'h1);
    wait_cyc(120);
    chk(!rst_pin_low && cpu_rst && bus_clk_en, "R3",
        {5'b0, rst_pin_low, cpu_rst, bus_clk_en}, 8'h3);
    wait_cyc(100);
    chk(!cpu_rst && bus_clk_en, "R3", {6'b0, cpu_rst, bus_clk_en}, 8'h1);
    // R9: wake while running is ignored
    pulse_wake(1'b1);
    wait_cyc(10);
    chk(!cpu_rst && bus_clk_en, "R9", {6'b0, cpu_rst, bus_clk_en}, 8'h1);
    // R6 / R8: short recovery
    pulse_stop();
    chk(!bus_clk_en, "R6", {7'b0, bus_clk_en}, 8'h0);
    wait_cyc(5);
    pulse_stop();
    pulse_wake(1'b1);
    wait_cyc(20);
    chk(!bus_clk_en, "R8", {7'b0, bus_clk_en}, 8'h0);
    wait_cyc(20);
    chk(bus_clk_en, "R8", {7'b0, bus_clk_en}, 8'h1);
    // R7: long recovery
    pulse_stop();
    wait_cyc(30);
    pulse_wake(1'b0);
    wait_cyc(2000);
    chk(!bus_clk_en, "R7", {7'b0, bus_clk_en}, 8'h0);
    wait_cyc(2200);
    chk(bus_clk_en, "R7", {7'b0, bus_clk_en}, 8'h1);
    // R10: exactly two ticks in any 8192-cycle run window, never adjacent
    ticks = 0; prev = 1'b0;
    for (int i = 0; i < 8192; i++) begin
      @(negedge clk);
      if (wdog_tick) ticks++;
      if (wdog_tick && prev) chk(1'b0, "R10 adjacent", 8'h1, 8'h0);
      prev = wdog_tick;
    end
    chk(ticks == 2, "R10", 8'(ticks), 8'd2);
    // R5: clear, then supply trip
    @(negedge clk) stat_clr = 1'b1;
    @(negedge clk) stat_clr = 1'b0;
    chk(rst_status == 2'b00, "R5", {6'b0, rst_status}, 8'h0);
    @(negedge clk) lvd_trip = 1'b1;
    @(negedge clk) lvd_trip = 1'b0;
    chk(rst_status == 2'b10 && rst_pin_low, "R5", {5'b0, rst_pin_low, rst_status}, 8'h6);
    // R4: second trip restarts the stretch
    wait_cyc(2000);
    @(negedge clk) lvd_trip = 1'b1;
    @(negedge clk) lvd_trip = 1'b0;
    wait_cyc(3000);
    chk(rst_pin_low, "R4", {7'b0, rst_pin_low}, 8'h1);
    wait_cyc(1120);
    chk(!rst_pin_low && cpu_rst, "R4", {6'b0, rst_pin_low, cpu_rst}, 8'h1);
    wait_cyc(200);
    // R11: power-on request during stop
    pulse_stop();
    wait_cyc(10);
    @(negedge clk) por_req = 1'b1;
    @(negedge clk) por_req = 1'b0;
    chk(rst_pin_low && rst_status == 2'b01, "R11", {5'b0, rst_pin_low, rst_status}, 8'h5);
    wait_cyc(50);
    // R5: both sources together, power-on wins
    @(negedge clk) begin por_req = 1'b1; lvd_trip = 1'b1; end
    @(negedge clk) begin por_req = 1'b0; lvd_trip = 1'b0; end
    chk(rst_status == 2'b01, "R5", {6'b0, rst_status}, 8'h1);
    wait_cyc(4300);
    chk(!cpu_rst && bus_clk_en, "R3", {6'b0, cpu_rst, bus_clk_en}, 8'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule